// File: doc/BRIEF.md
# I2C Register Target

This block is the target side of a two-wire serial bus, with a fixed 7-bit device address and a small bank of byte registers. Both bus lines are brought into the system clock domain through synchronizer chains. START and STOP are recognised from the synchronized levels, and the address frame that follows a START is shifted in. The block answers with an acknowledge only when the frame names its own address. The system clock must run at least eight times faster than SCL.

In a write, the first byte after the address loads a register pointer. Each byte after that is stored at the pointer, and the pointer then advances, wrapping at the end of the bank. In a read, the block sends the register under the pointer MSB first and advances the pointer after every byte. It keeps sending while the controller acknowledges, and goes silent after a not-acknowledge. The pointer is a full byte wide and survives between transfers, so a write of the pointer followed by a repeated START and a read fetches from any register. Local logic has its own write port and a combinational read port on the same bank.

The SDA output is open-drain. `sda_oe` high means the line is pulled low. The controller that runs the state register has these states:
- ST_IDLE: no transfer.
- ST_ADDR: shifting in the address frame. ST_ADDR goes to ST_ADDR_ACK on a match and to ST_IGNORE on a mismatch.
- ST_ADDR_ACK: the acknowledge slot for the address. It goes to ST_PTR for a write and to ST_RDATA for a read.
- ST_PTR: receiving the pointer byte, then ST_PTR_ACK, then ST_WDATA.
- ST_WDATA and ST_WDATA_ACK: receiving data bytes and their acknowledge slots, alternating.
- ST_RDATA: sending a byte, then ST_RACK.
- ST_RACK: sampling the controller's acknowledge. An ACK returns to ST_RDATA and a NACK goes to ST_IGNORE.
- ST_IGNORE: silent until the next START or STOP.

Any STOP goes to ST_IDLE. Any START goes to ST_ADDR.

Top module: `i2c_regtarget`

## Requirements
- R1: After reset, `sda_oe` is 0, every register reads 0 and the pointer is 0.
- R2: SDA falling while SCL is high is a START. A START at any point, including in the middle of a byte, releases SDA and restarts address reception. SDA rising while SCL is high is a STOP. A STOP releases SDA and returns to idle.
- R3: The address frame is received MSB first: seven address bits, then a direction bit (0 = write, 1 = read). On a match, SDA is held low for the whole high time of the ninth SCL pulse. SDA is never driven while a byte is being received.
- R4: On an address mismatch, SDA stays released for the acknowledge slot and for all further bytes until the next START.
- R5: In a write, the first byte loads the pointer. Each later byte is stored at register `pointer` and acknowledged, and the pointer then advances by one, with the value NREGS-1 wrapping to 0.
- R6: A pointer byte whose value is NREGS or greater is answered with NACK. Data bytes written while the pointer is out of range are answered with NACK and are not stored.
- R7: In a read, the register under the pointer is sent MSB first, and the pointer advances after each byte, wrapping at NREGS. Bytes continue while the controller acknowledges. The pointer persists across transfers.
- R8: After the controller answers a read byte with NACK, SDA is not driven until the next START or STOP.
- R9: A read while the pointer is out of range returns 8'hFF, with SDA released, and leaves the pointer unchanged.
- R10: `loc_rdata` shows register `loc_idx` combinationally, and `loc_we` stores `loc_wdata` there. When a bus write and a local write hit the same register in the same cycle, the bus value is kept. Writes to different registers both land.
- R11: `sda_oe` changes only while the synchronized SCL is low. The one exception is the release that follows a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as sensed at the pin |
| sda_in | input | 1 | Bus data line as sensed at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| loc_we | input | 1 | Local write strobe |
| loc_idx | input | $clog2(NREGS) | Local register index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Register at `loc_idx` |

## Verification
A data byte's bus store and a local store can fall in the same clock cycle. The bus store happens on the third system clock after SCL falls at the end of the byte. The bench raises `loc_wdata` and `loc_we` over exactly that window, once aimed at the bus target register and once at a different register. It then reads the bank back through the local port: the bus value must survive the clash, and both values must land when the registers differ. A START or STOP arriving in the middle of a byte is the other overlap. It is provoked after three and after four address bits and judged by the acknowledge of the frame that follows.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Brings both bus lines into the clock domain and derives edge/condition pulses.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;
    localparam int L_SCL = 1;
    localparam int L_SDA = 0;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    assign scl_s     = synced[L_SCL];
    assign sda_s     = synced[L_SDA];
    assign scl_rise  =  synced[L_SCL] & ~prev[L_SCL];
    assign scl_fall  = ~synced[L_SCL] &  prev[L_SCL];
    assign start_det =  synced[L_SCL] &  prev[L_SCL] &  prev[L_SDA] & ~synced[L_SDA];
    assign stop_det  =  synced[L_SCL] &  prev[L_SCL] & ~prev[L_SDA] &  synced[L_SDA];

endmodule

// File: rtl/i2c_tgt_regs.sv
// Byte register bank with a bus port and a local port; bus write has priority.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [IDX_W-1:0]  bus_ridx,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              loc_we,
    input  logic [IDX_W-1:0]  loc_idx,
    input  logic [BYTE_W-1:0] loc_wdata,
    output logic [BYTE_W-1:0] loc_rdata
);

    logic [NREGS-1:0][BYTE_W-1:0] bank;

    for (genvar g = 0; g < NREGS; g++) begin : g_ent
        logic [BYTE_W-1:0] q;
        logic              hit_bus;
        logic              hit_loc;

        assign hit_bus = bus_we && (bus_idx == IDX_W'(g));
        assign hit_loc = loc_we && (loc_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit_bus) begin
                q <= bus_wdata;
            end else if (hit_loc) begin
                q <= loc_wdata;
            end
        end

        assign bank[g] = q;
    end

    assign bus_rdata = bank[bus_ridx];
    assign loc_rdata = bank[loc_idx];

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Protocol controller: address match, pointer handling, byte send/receive, ack slots.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NREGS    = 8,
    parameter int         IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              bus_we,
    output logic [IDX_W-1:0]  bus_idx,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              sda_oe,
    output tgt_state_e        state_o
);

    localparam logic [BYTE_W-1:0] NREGS_B = BYTE_W'(NREGS);
    localparam logic [BYTE_W-1:0] LAST_B  = BYTE_W'(NREGS - 1);
    localparam logic [3:0]        FULL    = 4'd8;
    localparam logic [3:0]        LASTBIT = 4'd7;

    tgt_state_e        state, nstate;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic [3:0]        bcnt;
    logic              mack;
    logic              oe_q;

    logic              byte_full;
    logic              rx_done;
    logic              addr_hit;
    logic              ptr_ok;
    logic              shreg_ok;
    logic [BYTE_W-1:0] ptr_next;
    logic [BYTE_W-1:0] tx_byte;

    assign byte_full = (bcnt == FULL);
    assign rx_done   = byte_full && scl_fall;
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign ptr_ok    = (ptr < NREGS_B);
    assign shreg_ok  = (shreg < NREGS_B);
    assign ptr_next  = (ptr == LAST_B) ? '0 : ptr + BYTE_W'(1);
    assign tx_byte   = ptr_ok ? rd_byte : 8'hFF;

    assign rd_idx    = ptr[IDX_W-1:0];
    assign bus_idx   = ptr[IDX_W-1:0];
    assign bus_wdata = shreg;
    assign bus_we    = (state == ST_WDATA) && rx_done && ptr_ok && !start_det && !stop_det;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next-state decision
    always_comb begin
        nstate = state;
        if (stop_det) begin
            nstate = ST_IDLE;
        end else if (start_det) begin
            nstate = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_IGNORE:    nstate = ST_IGNORE;
                ST_ADDR:      if (rx_done)  nstate = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nstate = shreg[0] ? ST_RDATA : ST_PTR;
                ST_PTR:       if (rx_done)  nstate = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) nstate = ST_WDATA;
                ST_WDATA:     if (rx_done)  nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nstate = ST_WDATA;
                ST_RDATA:     if (scl_fall && bcnt == LASTBIT) nstate = ST_RACK;
                ST_RACK:      if (scl_fall) nstate = mack ? ST_RDATA : ST_IGNORE;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            shreg <= '0;
            ptr   <= '0;
            bcnt  <= '0;
            mack  <= 1'b0;
        end else if (stop_det || start_det) begin
            oe_q <= 1'b0;
            bcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && !byte_full) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        bcnt  <= bcnt + 4'd1;
                    end
                    if (rx_done) begin
                        bcnt <= '0;
                        if (state == ST_ADDR) begin
                            oe_q <= addr_hit;
                        end else if (state == ST_PTR) begin
                            ptr  <= shreg;
                            oe_q <= shreg_ok;
                        end else begin
                            oe_q <= ptr_ok;
                            if (ptr_ok) begin
                                ptr <= ptr_next;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (shreg[0]) begin
                            shreg <= tx_byte;
                            oe_q  <= ~tx_byte[BYTE_W-1];
                            bcnt  <= '0;
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        oe_q <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bcnt == LASTBIT) begin
                            oe_q <= 1'b0;
                            if (ptr_ok) begin
                                ptr <= ptr_next;
                            end
                        end else begin
                            bcnt  <= bcnt + 4'd1;
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end
                    if (scl_fall && mack) begin
                        shreg <= tx_byte;
                        oe_q  <= ~tx_byte[BYTE_W-1];
                        bcnt  <= '0;
                    end
                end
                ST_IDLE, ST_IGNORE: begin
                    oe_q <= 1'b0;
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe  = oe_q;
    assign state_o = state;

endmodule

// File: rtl/i2c_regtarget.sv
module i2c_regtarget
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         NREGS       = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDX_W       = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              loc_we,
    input  logic [IDX_W-1:0]  loc_idx,
    input  logic [BYTE_W-1:0] loc_wdata,
    output logic [BYTE_W-1:0] loc_rdata
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              bus_we;
    logic [IDX_W-1:0]  bus_idx, rd_idx;
    logic [BYTE_W-1:0] bus_wdata, rd_byte;
    tgt_state_e        fsm_state;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .rd_idx    (rd_idx),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .sda_oe    (sda_oe),
        .state_o   (fsm_state)
    );

    i2c_tgt_regs #(.NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_ridx  (rd_idx),
        .bus_rdata (rd_byte),
        .loc_we    (loc_we),
        .loc_idx   (loc_idx),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input tgt_state_e fsm_state
);

    // R2: STOP releases the line and returns to idle
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && fsm_state == ST_IDLE));

    // R2: START restarts address reception with the line released
    p_start_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (!sda_oe && fsm_state == ST_ADDR));

    // R1: idle never drives
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> !sda_oe);

    // R3: no driving while a byte is being received
    p_rx_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ADDR || fsm_state == ST_PTR || fsm_state == ST_WDATA) |-> !sda_oe);

    // R3: entering the address acknowledge slot pulls the line low
    p_addr_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_state) == ST_ADDR && fsm_state == ST_ADDR_ACK) |-> sda_oe);

    // R4 / R8: ignore state is silent
    p_ignore_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IGNORE) |-> !sda_oe);

    // R7: controller acknowledge slot is never driven by the target
    p_rack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RACK) |-> !sda_oe);

    // R11: output moves only while SCL is low, except release on START/STOP
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

bind i2c_regtarget i2c_tgt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .fsm_state (fsm_state)
);

// File: tb/i2c_regtarget_tb.sv
module i2c_regtarget_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 10;
    localparam logic [6:0] DEV        = 7'h2A;
    localparam int         NREGS      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic       loc_we = 1'b0;
    logic [2:0] loc_idx = '0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;

    assign sda_line = sda_m & ~sda_oe;

    int         n_chk = 0;
    int         n_fail = 0;
    int         oe_cnt = 0;
    bit         done = 1'b0;
    logic [7:0] exp_reg [NREGS];

    i2c_regtarget #(.DEV_ADDR(DEV), .NREGS(NREGS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .loc_we    (loc_we),
        .loc_idx   (loc_idx),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

    always @(posedge clk) if (sda_oe) oe_cnt++;

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREGS; i++) begin
            loc_idx = 3'(i);
            @(negedge clk);
            check(loc_rdata == exp_reg[i], req, loc_rdata, exp_reg[i]);
        end
    endtask

    task automatic m_start();
        if (!scl_m) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
        end
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic m_bit_out(input bit b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic m_write_byte(input logic [7:0] d, input bit col, output bit ack);
        bit a0, a1;
        for (int i = 7; i >= 0; i--) begin
            m_bit_out(d[i]);
            if (i == 0 && col) begin
                @(posedge clk);
                @(posedge clk);
                @(negedge clk);
                loc_we = 1'b1;
                @(negedge clk);
                loc_we = 1'b0;
                wq(Q - 2);
            end else begin
                wq(Q);
            end
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(2);
        a0 = sda_line;
        wq(2*Q - 3);
        a1 = sda_line;
        wq(1);
        scl_m = 1'b0; wq(Q);
        ack = !a0 && !a1;
    endtask

    task automatic m_read_byte(input bit mack, output logic [7:0] d, output bit stable_ok);
        bit x, y;
        stable_ok = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(1);
            x = sda_line;
            wq(2*Q - 2);
            y = sda_line;
            if (x != y) stable_ok = 1'b0;
            d[i] = x;
            wq(1);
            scl_m = 1'b0;
        end
        wq(Q/2);
        sda_m = mack ? 1'b0 : 1'b1;
        wq(Q/2);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q/2);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p, output bit ack_p);
        bit ack;
        m_start();
        m_write_byte({DEV, 1'b0}, 1'b0, ack);
        check(ack, "R3 write address ack", ack, 1);
        m_write_byte(p, 1'b0, ack_p);
    endtask

    initial begin
        bit         ack;
        bit         st;
        logic [7:0] d;

        for (int i = 0; i < NREGS; i++) exp_reg[i] = '0;
        wq(5);
        check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        check_regs("R1 reset register value");
        rst_n = 1'b1;
        wq(5);

        // Address sweep
        for (int a = 0; a < 128; a++) begin
            m_start();
            m_write_byte({7'(a), 1'b0}, 1'b0, ack);
            check(ack == (7'(a) == DEV), "R3 address ack vs match", ack, (7'(a) == DEV));
            if (7'(a) != DEV && (a % 16) == 5) begin
                oe_cnt = 0;
                m_write_byte(8'h00, 1'b0, ack);
                check(!ack && oe_cnt == 0, "R4 silent after mismatch", oe_cnt, 0);
            end
            m_stop();
        end

        // Pointer range sweep
        for (int p = 0; p < 16; p++) begin
            set_ptr(8'(p), ack);
            check(ack == (p < NREGS), "R6 pointer byte ack vs range", ack, (p < NREGS));
            m_stop();
        end

        // Write burst with wrap
        set_ptr(8'd6, ack);
        check(ack, "R5 pointer ack", ack, 1);
        for (int k = 0; k < 10; k++) begin
            d = 8'(8'h11 * k + 3);
            exp_reg[(6 + k) % NREGS] = d;
            m_write_byte(d, 1'b0, ack);
            check(ack, "R5 data ack", ack, 1);
        end
        m_stop();
        check_regs("R5 stored burst with wrap");

        // Read burst via repeated start
        set_ptr(8'd5, ack);
        m_start();
        m_write_byte({DEV, 1'b1}, 1'b0, ack);
        check(ack, "R3 read address ack", ack, 1);
        for (int k = 0; k < 10; k++) begin
            m_read_byte(k != 9, d, st);
            check(d == exp_reg[(5 + k) % NREGS], "R7 read data", d, exp_reg[(5 + k) % NREGS]);
            check(st, "R11 data stable while SCL high", st, 1);
        end
        oe_cnt = 0;
        m_read_byte(1'b0, d, st);
        check(d == 8'hFF && oe_cnt == 0, "R8 silent after controller NACK", d, 8'hFF);
        m_stop();

        // Pointer persistence: 5 + 10 reads -> 7
        m_start();
        m_write_byte({DEV, 1'b1}, 1'b0, ack);
        m_read_byte(1'b1, d, st);
        check(d == exp_reg[7], "R7 pointer kept across transfers", d, exp_reg[7]);
        m_read_byte(1'b0, d, st);
        check(d == exp_reg[0], "R7 read pointer wrap", d, exp_reg[0]);
        m_stop();

        // Out-of-range pointer
        set_ptr(8'd200, ack);
        check(!ack, "R6 out-of-range pointer NACK", ack, 0);
        m_write_byte(8'h5A, 1'b0, ack);
        check(!ack, "R6 out-of-range data NACK", ack, 0);
        m_stop();
        check_regs("R6 nothing stored out of range");
        m_start();
        m_write_byte({DEV, 1'b1}, 1'b0, ack);
        m_read_byte(1'b1, d, st);
        check(d == 8'hFF, "R9 out-of-range read value", d, 8'hFF);
        m_read_byte(1'b0, d, st);
        check(d == 8'hFF, "R9 pointer held out of range", d, 8'hFF);
        m_stop();

        // Mid-byte STOP and mid-byte START
        m_start();
        for (int i = 7; i >= 4; i--) begin
            m_bit_out(DEV[(i > 0) ? i - 1 : 0]);
            wq(Q);
        end
        m_stop();
        check(sda_oe == 1'b0, "R2 STOP mid-byte releases", sda_oe, 0);
        m_start();
        for (int i = 0; i < 3; i++) begin
            m_bit_out(1'b1);
            wq(Q);
        end
        m_start();
        m_write_byte({DEV, 1'b0}, 1'b0, ack);
        check(ack, "R2 START mid-byte restarts frame", ack, 1);
        m_write_byte(8'd2, 1'b0, ack);
        m_write_byte(8'hA5, 1'b0, ack);
        exp_reg[2] = 8'hA5;
        m_stop();
        loc_idx = 3'd2;
        @(negedge clk);
        check(loc_rdata == 8'hA5, "R2 transfer after restart stored", loc_rdata, 8'hA5);

        // Local port
        loc_idx = 3'd4;
        loc_wdata = 8'h3C;
        @(negedge clk);
        loc_we = 1'b1;
        @(negedge clk);
        loc_we = 1'b0;
        exp_reg[4] = 8'h3C;
        check(loc_rdata == 8'h3C, "R10 local write readback", loc_rdata, 8'h3C);
        set_ptr(8'd4, ack);
        m_start();
        m_write_byte({DEV, 1'b1}, 1'b0, ack);
        m_read_byte(1'b0, d, st);
        check(d == 8'h3C, "R10 local write seen on bus", d, 8'h3C);
        m_stop();

        // Same-cycle collision, same register: bus wins
        loc_idx = 3'd1;
        loc_wdata = 8'h99;
        set_ptr(8'd1, ack);
        m_write_byte(8'h77, 1'b1, ack);
        m_stop();
        exp_reg[1] = 8'h77;

        // Same-cycle collision, different registers: both land
        loc_idx = 3'd6;
        loc_wdata = 8'h66;
        set_ptr(8'd3, ack);
        m_write_byte(8'h44, 1'b1, ack);
        m_stop();
        exp_reg[3] = 8'h44;
        exp_reg[6] = 8'h66;
        check_regs("R10 collision outcome");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule